// File: doc/BRIEF.md
# System Control Register File

This block is the byte-wide I/O register set that sits on a small processor board's port bus. It matches a 16-bit port address against a fixed list of ports. A single-cycle write strobe updates the control bits it holds, and a single-cycle read strobe returns a byte. It stores the soft-reset request and byte-order selection, a disk activity indicator, a four-bit cache control field and the port-space map type. It also holds a two-byte scratch pair and returns a set of fixed identification and equipment values.

Some ports are strobes only. A write to either of two ports raises a one-clock toggle pulse toward an NVRAM password-lock controller. A write to the cache-invalidate port is accepted and changes nothing. A write to any port outside the write map is dropped and sets a sticky error flag. The reset request and byte-order selection leave the block as levels. The NVRAM, the processor reset logic and the cache are outside this block.

Top module: `sysctl_regfile`

## Requirements
- R1: While `rst_n` is low, every stored bit is 0: `reset_req`, `little_endian`, `disk_led`, `cache_ctl`, `noncontig_map`, both scratch bytes, `wr_err`, both lock pulses and `io_rdata`. After reset the map is contiguous, the byte order is big-endian and no reset is requested.
- R2: When `io_rd` is high at a clock edge, `io_rdata` shows the addressed port's byte after that edge. It keeps that byte until the next read.
- R3: A write to port 0x0092 sets `reset_req` to data bit 0 as a level. It sets `little_endian` to data bit 1 (1 = little-endian, 0 = big-endian). A read of 0x0092 returns 0x00.
- R4: Ports 0x0800, 0x0802 and 0x0803 read 0xEF, 0xAD and 0xE0. A write to any of them changes no output and does not set `wr_err`.
- R5: Port 0x080C reads 0x3C, port 0x0810 reads 0x39, port 0x0818 reads 0x00 and port 0x0823 reads 0x03.
- R6: A write to port 0x0808 sets `disk_led` to data bit 0.
- R7: A write of any value to port 0x0810 raises `lock_toggle_a` for exactly one clock, in the cycle after the write. A write to port 0x0812 does the same on `lock_toggle_b`. The two pulses never overlap.
- R8: A write to port 0x081C stores data bits 3:0 on `cache_ctl`. A read of 0x081C returns them with bits 7:4 as zero.
- R9: A write to port 0x0850 stores data bit 0 on `noncontig_map` (0 = contiguous, 1 = non-contiguous). A read of 0x0850 returns 0x00 or 0x01.
- R10: A write to port 0x0814 changes no output and does not set `wr_err`. A read of 0x0814 returns 0xFF.
- R11: A read of any port not listed here returns 0xFF, and 0x0808 and 0x0812 count as unlisted for reads. A write to any port outside the write map (0x0092, 0x0398, 0x0399, 0x0800, 0x0802, 0x0803, 0x0808, 0x0810, 0x0812, 0x0814, 0x081C, 0x0850) changes nothing and sets `wr_err`. `wr_err` stays set until reset.
- R12: Ports 0x0398 and 0x0399 each store a full byte and read it back. The two bytes are independent.
- R13: When a read and a write hit the same port at one edge, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| io_addr | input | 16 | Port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| io_rdata | output | 8 | Registered read data |
| reset_req | output | 1 | Soft-reset request level |
| little_endian | output | 1 | Byte order: 1 = little-endian |
| disk_led | output | 1 | Disk activity indicator |
| cache_ctl | output | 4 | Cache control field |
| noncontig_map | output | 1 | Port-space map type: 1 = non-contiguous |
| lock_toggle_a | output | 1 | One-clock toggle pulse, lock line 1 |
| lock_toggle_b | output | 1 | One-clock toggle pulse, lock line 2 |
| wr_err | output | 1 | Sticky flag: a write hit a port outside the write map |

## Verification
The bench targets the ports whose read and write maps differ. Port 0x0810 reads a constant but pulses a lock line on write, so a decode that merges the two paths would either store into it or fail to pulse. Writes to the read-only identification ports and to the invalidate port must leave `wr_err` clear, while writes to read-only equipment ports must set it; a design that treats these two groups alike gets one of the cases wrong. Reads of the write-only ports 0x0808 and 0x0812 must return 0xFF rather than the stored state. A read and write to the same scratch port in one edge must return the old byte, which catches a read path taken after the register update.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam logic [15:0] PA_SPECIAL = 16'h0092;
  localparam logic [15:0] PA_CPUCFG  = 16'h0800;
  localparam logic [15:0] PA_FEAT    = 16'h0802;
  localparam logic [15:0] PA_STAT    = 16'h0803;
  localparam logic [15:0] PA_DISK    = 16'h0808;
  localparam logic [15:0] PA_EQUIP   = 16'h080C;
  localparam logic [15:0] PA_XFEAT   = 16'h0810;
  localparam logic [15:0] PA_LOCK2   = 16'h0812;
  localparam logic [15:0] PA_L2INV   = 16'h0814;
  localparam logic [15:0] PA_KEY     = 16'h0818;
  localparam logic [15:0] PA_CACHE   = 16'h081C;
  localparam logic [15:0] PA_L2STAT  = 16'h0823;
  localparam logic [15:0] PA_MAP     = 16'h0850;
  localparam logic [15:0] PA_SCR     = 16'h0398;

  localparam logic [7:0] K_CPUCFG = 8'hEF;
  localparam logic [7:0] K_FEAT   = 8'hAD;
  localparam logic [7:0] K_STAT   = 8'hE0;
  localparam logic [7:0] K_EQUIP  = 8'h3C;
  localparam logic [7:0] K_XFEAT  = 8'h39;
  localparam logic [7:0] K_L2STAT = 8'h03;
  localparam logic [7:0] K_NONE   = 8'hFF;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SPECIAL, SEL_CPUCFG, SEL_FEAT, SEL_STAT, SEL_DISK,
    SEL_EQUIP, SEL_XFEAT, SEL_LOCK2, SEL_L2INV, SEL_KEY, SEL_CACHE,
    SEL_L2STAT, SEL_MAP, SEL_SCR
  } port_sel_e;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NSCR   = 2,
  parameter int SCR_IW = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output port_sel_e         sel,
  output logic [SCR_IW-1:0] scr_idx,
  output logic              wr_known
);

  logic [ADDR_W-1:0] scr_off;

  assign scr_off = addr - ADDR_W'(PA_SCR);

  always_comb begin
    sel     = SEL_NONE;
    scr_idx = '0;
    case (addr)
      ADDR_W'(PA_SPECIAL): sel = SEL_SPECIAL;
      ADDR_W'(PA_CPUCFG):  sel = SEL_CPUCFG;
      ADDR_W'(PA_FEAT):    sel = SEL_FEAT;
      ADDR_W'(PA_STAT):    sel = SEL_STAT;
      ADDR_W'(PA_DISK):    sel = SEL_DISK;
      ADDR_W'(PA_EQUIP):   sel = SEL_EQUIP;
      ADDR_W'(PA_XFEAT):   sel = SEL_XFEAT;
      ADDR_W'(PA_LOCK2):   sel = SEL_LOCK2;
      ADDR_W'(PA_L2INV):   sel = SEL_L2INV;
      ADDR_W'(PA_KEY):     sel = SEL_KEY;
      ADDR_W'(PA_CACHE):   sel = SEL_CACHE;
      ADDR_W'(PA_L2STAT):  sel = SEL_L2STAT;
      ADDR_W'(PA_MAP):     sel = SEL_MAP;
      default: begin
        if (scr_off < ADDR_W'(NSCR)) begin
          sel     = SEL_SCR;
          scr_idx = SCR_IW'(scr_off);
        end
      end
    endcase
  end

  // Ports that accept a write; read-only equipment ports are excluded
  always_comb begin
    case (sel)
      SEL_SPECIAL, SEL_CPUCFG, SEL_FEAT, SEL_STAT, SEL_DISK, SEL_XFEAT,
      SEL_LOCK2, SEL_L2INV, SEL_CACHE, SEL_MAP, SEL_SCR: wr_known = 1'b1;
      default:                                           wr_known = 1'b0;
    endcase
  end

endmodule

// File: rtl/sysctl_state.sv
module sysctl_state
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTL_W  = 4,
  parameter int NSCR   = 2,
  parameter int SCR_IW = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  port_sel_e                   sel,
  input  logic [SCR_IW-1:0]           scr_idx,
  input  logic                        wr_known,
  input  logic [DATA_W-1:0]           wdata,
  output logic                        reset_req_q,
  output logic                        endian_q,
  output logic                        disk_q,
  output logic [CTL_W-1:0]            cache_q,
  output logic                        map_q,
  output logic [NSCR-1:0][DATA_W-1:0] scr_q,
  output logic                        err_q,
  output logic                        lock_a_q,
  output logic                        lock_b_q
);

  logic en_special, en_disk, en_cache, en_map, en_err;
  logic lock_a_d, lock_b_d;

  always_comb begin
    en_special = wr && (sel == SEL_SPECIAL);
    en_disk    = wr && (sel == SEL_DISK);
    en_cache   = wr && (sel == SEL_CACHE);
    en_map     = wr && (sel == SEL_MAP);
    en_err     = wr && !wr_known;
    lock_a_d   = wr && (sel == SEL_XFEAT);
    lock_b_d   = wr && (sel == SEL_LOCK2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reset_req_q <= 1'b0;
      endian_q    <= 1'b0;
    end else if (en_special) begin
      reset_req_q <= wdata[0];
      endian_q    <= wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       disk_q <= 1'b0;
    else if (en_disk) disk_q <= wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cache_q <= '0;
    else if (en_cache) cache_q <= wdata[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      map_q <= 1'b0;
    else if (en_map) map_q <= wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (en_err) err_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_a_q <= 1'b0;
      lock_b_q <= 1'b0;
    end else begin
      lock_a_q <= lock_a_d;
      lock_b_q <= lock_b_d;
    end
  end

  for (genvar i = 0; i < NSCR; i++) begin : g_scr
    logic en_scr;
    assign en_scr = wr && (sel == SEL_SCR) && (scr_idx == SCR_IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      scr_q[i] <= '0;
      else if (en_scr) scr_q[i] <= wdata;
    end
  end

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTL_W  = 4,
  parameter int NSCR   = 2,
  parameter int SCR_IW = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd,
  input  port_sel_e                   sel,
  input  logic [SCR_IW-1:0]           scr_idx,
  input  logic [CTL_W-1:0]            cache_q,
  input  logic                        map_q,
  input  logic [NSCR-1:0][DATA_W-1:0] scr_q,
  output logic [DATA_W-1:0]           rdata_q
);

  logic [DATA_W-1:0] rd_val;

  always_comb begin
    case (sel)
      SEL_SPECIAL: rd_val = '0;
      SEL_CPUCFG:  rd_val = DATA_W'(K_CPUCFG);
      SEL_FEAT:    rd_val = DATA_W'(K_FEAT);
      SEL_STAT:    rd_val = DATA_W'(K_STAT);
      SEL_EQUIP:   rd_val = DATA_W'(K_EQUIP);
      SEL_XFEAT:   rd_val = DATA_W'(K_XFEAT);
      SEL_KEY:     rd_val = '0;
      SEL_CACHE:   rd_val = DATA_W'(cache_q);
      SEL_L2STAT:  rd_val = DATA_W'(K_L2STAT);
      SEL_MAP:     rd_val = DATA_W'(map_q);
      SEL_SCR:     rd_val = scr_q[scr_idx];
      default:     rd_val = DATA_W'(K_NONE);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rd_val;
  end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CTL_W  = 4,
  parameter int NSCR   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [DATA_W-1:0] io_rdata,
  output logic              reset_req,
  output logic              little_endian,
  output logic              disk_led,
  output logic [CTL_W-1:0]  cache_ctl,
  output logic              noncontig_map,
  output logic              lock_toggle_a,
  output logic              lock_toggle_b,
  output logic              wr_err
);

  localparam int SCR_IW = (NSCR > 1) ? $clog2(NSCR) : 1;

  port_sel_e                   sel;
  logic [SCR_IW-1:0]           scr_idx;
  logic                        wr_known;
  logic [NSCR-1:0][DATA_W-1:0] scr_q;

  sysctl_decode #(.ADDR_W(ADDR_W), .NSCR(NSCR), .SCR_IW(SCR_IW)) u_dec (
    .addr     (io_addr),
    .sel      (sel),
    .scr_idx  (scr_idx),
    .wr_known (wr_known)
  );

  sysctl_state #(.DATA_W(DATA_W), .CTL_W(CTL_W), .NSCR(NSCR), .SCR_IW(SCR_IW)) u_st (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (io_wr),
    .sel         (sel),
    .scr_idx     (scr_idx),
    .wr_known    (wr_known),
    .wdata       (io_wdata),
    .reset_req_q (reset_req),
    .endian_q    (little_endian),
    .disk_q      (disk_led),
    .cache_q     (cache_ctl),
    .map_q       (noncontig_map),
    .scr_q       (scr_q),
    .err_q       (wr_err),
    .lock_a_q    (lock_toggle_a),
    .lock_b_q    (lock_toggle_b)
  );

  sysctl_rdmux #(.DATA_W(DATA_W), .CTL_W(CTL_W), .NSCR(NSCR), .SCR_IW(SCR_IW)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (io_rd),
    .sel     (sel),
    .scr_idx (scr_idx),
    .cache_q (cache_ctl),
    .map_q   (noncontig_map),
    .scr_q   (scr_q),
    .rdata_q (io_rdata)
  );

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CTL_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic [1:0]        wbits,
  input logic              io_wr,
  input logic              io_rd,
  input logic [DATA_W-1:0] io_rdata,
  input logic              reset_req,
  input logic              little_endian,
  input logic              lock_toggle_a,
  input logic              lock_toggle_b,
  input logic              wr_err
);

  // R2: read data holds between reads
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));

  // R3: port 0x0092 drives reset and byte order levels
  p_special_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == ADDR_W'(PA_SPECIAL)) |=>
      (reset_req == $past(wbits[0]) && little_endian == $past(wbits[1])));

  // R4: identification byte after one cycle
  p_id_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == ADDR_W'(PA_CPUCFG)) |=> io_rdata == DATA_W'(K_CPUCFG));

  // R4: write to read-only ID port does not touch the error flag
  p_id_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == ADDR_W'(PA_CPUCFG)) |=> $stable(wr_err));

  // R7: lock pulse follows a write
  p_lock_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == ADDR_W'(PA_XFEAT)) |=> lock_toggle_a);

  // R7: pulses never overlap
  p_lock_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lock_toggle_a, lock_toggle_b}));

  // R8: cache field reads back with upper bits clear
  p_cache_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == ADDR_W'(PA_CACHE)) |=> io_rdata[DATA_W-1:CTL_W] == '0);

  // R11: error flag is sticky
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);

endmodule

bind sysctl_regfile sysctl_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_W(CTL_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .io_addr       (io_addr),
  .wbits         (io_wdata[1:0]),
  .io_wr         (io_wr),
  .io_rd         (io_rd),
  .io_rdata      (io_rdata),
  .reset_req     (reset_req),
  .little_endian (little_endian),
  .lock_toggle_a (lock_toggle_a),
  .lock_toggle_b (lock_toggle_b),
  .wr_err        (wr_err)
);

// File: tb/sim_sysctl_regfile.sv
module sim_sysctl_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic        reset_req, little_endian, disk_led, noncontig_map;
  logic [3:0]  cache_ctl;
  logic        lock_toggle_a, lock_toggle_b, wr_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sysctl_regfile u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .reset_req(reset_req), .little_endian(little_endian), .disk_led(disk_led),
    .cache_ctl(cache_ctl), .noncontig_map(noncontig_map),
    .lock_toggle_a(lock_toggle_a), .lock_toggle_b(lock_toggle_b), .wr_err(wr_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_port(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd_port(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    v = io_rdata;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset_req", reset_req, 0);
    check("R1 little_endian", little_endian, 0);
    check("R1 disk_led", disk_led, 0);
    check("R1 cache_ctl", cache_ctl, 0);
    check("R1 noncontig_map", noncontig_map, 0);
    check("R1 locks", {lock_toggle_a, lock_toggle_b}, 0);
    check("R1 wr_err", wr_err, 0);
    check("R1 rdata", io_rdata, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_special();
    logic [7:0] v;
    wr_port(16'h0092, 8'h03);
    check("R3 reset_req set", reset_req, 1);
    check("R3 little_endian set", little_endian, 1);
    rd_port(16'h0092, v);
    check("R3 read 0x0092", v, 8'h00);
    repeat (2) @(negedge clk);
    check("R3 reset_req held", reset_req, 1);
    wr_port(16'h0092, 8'h02);
    check("R3 reset_req clear", reset_req, 0);
    check("R3 endian kept LE", little_endian, 1);
    wr_port(16'h0092, 8'h00);
    check("R3 big-endian", little_endian, 0);
  endtask

  task automatic t_ids();
    logic [7:0] v;
    rd_port(16'h0800, v); check("R4 0x0800", v, 8'hEF);
    rd_port(16'h0802, v); check("R4 0x0802", v, 8'hAD);
    rd_port(16'h0803, v); check("R4 0x0803", v, 8'hE0);
    repeat (3) @(negedge clk);
    check("R2 rdata held", io_rdata, 8'hE0);
    wr_port(16'h0800, 8'h00);
    wr_port(16'h0802, 8'hFF);
    wr_port(16'h0803, 8'h13);
    rd_port(16'h0800, v); check("R4 0x0800 after write", v, 8'hEF);
    rd_port(16'h0802, v); check("R4 0x0802 after write", v, 8'hAD);
    check("R4 no error", wr_err, 0);
    check("R4 outputs unchanged", {reset_req, little_endian, disk_led, cache_ctl, noncontig_map}, 0);
  endtask

  task automatic t_fixed();
    logic [7:0] v;
    rd_port(16'h080C, v); check("R5 0x080C", v, 8'h3C);
    rd_port(16'h0810, v); check("R5 0x0810", v, 8'h39);
    rd_port(16'h0818, v); check("R5 0x0818", v, 8'h00);
    rd_port(16'h0823, v); check("R5 0x0823", v, 8'h03);
  endtask

  task automatic t_disk();
    logic [7:0] v;
    wr_port(16'h0808, 8'hFF);
    check("R6 disk_led on", disk_led, 1);
    rd_port(16'h0808, v);
    check("R11 read 0x0808", v, 8'hFF);
    wr_port(16'h0808, 8'hFE);
    check("R6 disk_led off", disk_led, 0);
  endtask

  task automatic t_lock();
    wr_port(16'h0810, 8'h00);
    check("R7 lock_a high", lock_toggle_a, 1);
    check("R7 lock_b low", lock_toggle_b, 0);
    @(negedge clk);
    check("R7 lock_a one clock", lock_toggle_a, 0);
    wr_port(16'h0812, 8'hA5);
    check("R7 lock_b high", lock_toggle_b, 1);
    check("R7 lock_a low", lock_toggle_a, 0);
    @(negedge clk);
    check("R7 lock_b one clock", lock_toggle_b, 0);
  endtask

  task automatic t_cache();
    logic [7:0] v;
    wr_port(16'h081C, 8'hF6);
    check("R8 cache_ctl", cache_ctl, 4'h6);
    rd_port(16'h081C, v);
    check("R8 read 0x081C", v, 8'h06);
    wr_port(16'h081C, 8'h09);
    rd_port(16'h081C, v);
    check("R8 read 0x081C second", v, 8'h09);
  endtask

  task automatic t_map();
    logic [7:0] v;
    wr_port(16'h0850, 8'hFF);
    check("R9 noncontig", noncontig_map, 1);
    rd_port(16'h0850, v);
    check("R9 read 0x0850", v, 8'h01);
    wr_port(16'h0850, 8'hFE);
    check("R9 contiguous", noncontig_map, 0);
    rd_port(16'h0850, v);
    check("R9 read 0x0850 zero", v, 8'h00);
  endtask

  task automatic t_l2inv();
    logic [7:0] v;
    wr_port(16'h0814, 8'hFF);
    check("R10 no error", wr_err, 0);
    check("R10 cache kept", cache_ctl, 4'h9);
    rd_port(16'h0814, v);
    check("R10 read 0x0814", v, 8'hFF);
  endtask

  task automatic t_scratch();
    logic [7:0] v;
    wr_port(16'h0398, 8'hC3);
    wr_port(16'h0399, 8'h11);
    rd_port(16'h0398, v); check("R12 scratch 0", v, 8'hC3);
    rd_port(16'h0399, v); check("R12 scratch 1", v, 8'h11);
    @(negedge clk);
    io_addr = 16'h0399; io_wdata = 8'h5A; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    check("R13 old value on same-edge read", io_rdata, 8'h11);
    rd_port(16'h0399, v); check("R13 new value", v, 8'h5A);
    rd_port(16'h0398, v); check("R12 scratch 0 intact", v, 8'hC3);
  endtask

  task automatic t_undecoded();
    logic [7:0] v;
    rd_port(16'h0812, v); check("R11 read 0x0812", v, 8'hFF);
    rd_port(16'h1234, v); check("R11 read 0x1234", v, 8'hFF);
    rd_port(16'h039A, v); check("R11 read past scratch", v, 8'hFF);
    wr_port(16'h080C, 8'h00);
    check("R11 err on RO equip write", wr_err, 1);
    rd_port(16'h080C, v); check("R11 0x080C unchanged", v, 8'h3C);
    wr_port(16'h0092, 8'h00);
    repeat (2) @(negedge clk);
    check("R11 err sticky", wr_err, 1);
    t_reset();
    wr_port(16'h4000, 8'h77);
    check("R11 err on unmapped write", wr_err, 1);
    check("R11 outputs unchanged", {reset_req, little_endian, disk_led, cache_ctl, noncontig_map}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_special();
    t_ids();
    t_fixed();
    t_disk();
    t_lock();
    t_cache();
    t_map();
    t_l2inv();
    t_scratch();
    t_undecoded();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule